// File: doc/BRIEF.md
# Multilevel Staircase Program Sequencer

This block sequences the write of a row of two-bit-per-cell storage elements using a gate voltage that climbs in equal steps. On a start strobe it captures the desired data and the data currently held by the cells. It then sorts every cell into one of four groups by comparing charge levels: no work, an illegal request, a verified target, or a top-level target. An external pump converts the emitted step index into a voltage, and external sense circuitry answers with per-cell verify flags.

There are three phases. The first is a single compare cycle. The second is a pulse/verify loop that covers only the two intermediate levels. Each cell drops out of that loop once its own verify flag reports that it has arrived. The third is an unverified ramp for cells aimed at the highest charge level. It resumes at the step where the loop stopped and runs up to the last step. The number of clock cycles a pulse lasts is set per operation, so a slow pump can settle.

Top module: `mlc_stair_prog`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and cmp_err_o are low, pgm_en_o is all zero and step_o is 0.
- R2: A start_i high while idle captures wbuf_i, rdat_i and hold_i and begins an operation. A start_i high during an operation is ignored, and that operation's pulses, timing and flags are unchanged.
- R3: Cell codes order by charge as 11 < 10 < 01 < 00; cell k uses bits [2k+1:2k]. In the compare cycle, a cell needs programming only if its target is above its current level. If any target is below its current level, cmp_err_o is set, and such cells are never pulsed. Equal cells are never pulsed.
- R4: A cell whose target is 11 is never pulsed.
- R5: Phase 2 starts at step 0. Each step is a pulse of H cycles that enables the cells still in the phase-2 set, followed by one verify cycle with pgm_en_o all low. The step then advances by one. busy_o lasts 1 + (S+1)(H+1) cycles up to the end of phase 2, where S is the last step used.
- R6: In a verify cycle, a 10-target leaves the set if vfy_lo_i is high for it, and a 01-target leaves if vfy_hi_i is high for it. The other flag is ignored. A cell that has left is not pulsed again.
- R7: Phase 2 ends when the set is empty. If the verify at the last step (STEPS-1, 106 by default) still leaves cells in the set, the operation ends with done_o and fail_o high and phase 3 is skipped.
- R8: Phase 3 pulses the 00-target cells for H cycles per step without verify. It starts at the last phase-2 step, or at 0 if phase 2 had no cells, and runs through step STEPS-1 before done_o rises. It is skipped when there are no such cells.
- R9: H equals hold_i, and a hold_i of 0 acts as 1.
- R10: An operation with no cells to program ends right after the compare cycle. done_o stays high after the end until the next accepted start, and fail_o implies done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (idle only) |
| hold_i | input | HOLD_W | Pulse length per step in cycles |
| wbuf_i | input | 2*NCELL | Target data, 2 bits per cell |
| rdat_i | input | 2*NCELL | Present cell data, 2 bits per cell |
| vfy_lo_i | input | NCELL | Per-cell reached-10 verify flag |
| vfy_hi_i | input | NCELL | Per-cell reached-01 verify flag |
| step_o | output | STEP_W | Gate voltage step index |
| pgm_en_o | output | NCELL | Per-cell program pulse enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished |
| fail_o | output | 1 | Phase 2 ran out of steps |
| cmp_err_o | output | 1 | A target would remove charge |

## Verification
Random rows mix all sixteen target/present code pairs. Each cell gets its own step at which its low and high verify flags rise, and the two steps differ, so a design that picks the wrong flag for a level produces different pulse counts per cell. Directed rows cover these cases:
- an all-erased request, which gives the shortest run;
- charge-removing requests, which raise the error flag with no pulses;
- top-level-only rows with a hold of zero, which ramp from step 0;
- a verify landing exactly on the last step, which passes;
- a verify one step beyond it, which fails.

Per-cell pulse totals, the busy length and the final step separate these outcomes: the phase-3 start point, the length of each step, and verify-cycle timing.

// File: rtl/mlc_stair_pkg.sv
package mlc_stair_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMP, ST_P2_PULSE, ST_P2_VFY, ST_P3_PULSE
  } seq_st_e;

  // charge level: 11 -> 0, 10 -> 1, 01 -> 2, 00 -> 3
  function automatic logic [1:0] cell_lvl(input logic [1:0] code);
    return ~code;
  endfunction
endpackage

// File: rtl/mlc_cell_cmp.sv
module mlc_cell_cmp
  import mlc_stair_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic [2*NCELL-1:0] tgt_i,
  input  logic [2*NCELL-1:0] cur_i,
  output logic [NCELL-1:0]   need2_o,
  output logic [NCELL-1:0]   need3_o,
  output logic [NCELL-1:0]   err_o
);
  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    logic [1:0] t, c;
    logic       up;
    assign t          = tgt_i[2*g +: 2];
    assign c          = cur_i[2*g +: 2];
    assign up         = cell_lvl(t) > cell_lvl(c);
    assign err_o[g]   = cell_lvl(t) < cell_lvl(c);
    assign need2_o[g] = up && (t != 2'b00);
    assign need3_o[g] = up && (t == 2'b00);
  end
endmodule

// File: rtl/mlc_vfy_mask.sv
module mlc_vfy_mask #(
  parameter int NCELL = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NCELL-1:0]   load_val_i,
  input  logic               vfy_i,
  input  logic [2*NCELL-1:0] tgt_i,
  input  logic [NCELL-1:0]   vfy_lo_i,
  input  logic [NCELL-1:0]   vfy_hi_i,
  output logic [NCELL-1:0]   mask_o,
  output logic               nxt_empty_o
);
  logic [NCELL-1:0] mask_q, hit, nxt;

  for (genvar g = 0; g < NCELL; g++) begin : g_hit
    assign hit[g] = (tgt_i[2*g +: 2] == 2'b10) ? vfy_lo_i[g] : vfy_hi_i[g];
  end

  assign nxt         = mask_q & ~hit;
  assign nxt_empty_o = (nxt == '0);
  assign mask_o      = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= load_val_i;
    else if (vfy_i)  mask_q <= nxt;
  end

  // R6
  mask_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> (mask_q & ~$past(mask_q)) == '0);
endmodule

// File: rtl/mlc_stair_prog.sv
module mlc_stair_prog
  import mlc_stair_pkg::*;
#(
  parameter int NCELL  = 8,
  parameter int STEPS  = 107,
  parameter int HOLD_W = 4,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [HOLD_W-1:0]  hold_i,
  input  logic [2*NCELL-1:0] wbuf_i,
  input  logic [2*NCELL-1:0] rdat_i,
  input  logic [NCELL-1:0]   vfy_lo_i,
  input  logic [NCELL-1:0]   vfy_hi_i,
  output logic [STEP_W-1:0]  step_o,
  output logic [NCELL-1:0]   pgm_en_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic               cmp_err_o
);
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(STEPS - 1);

  seq_st_e            st_q;
  logic [2*NCELL-1:0] tgt_q, cur_q;
  logic [HOLD_W-1:0]  hold_q, hold_eff, reload, cnt_q;
  logic [STEP_W-1:0]  step_q;
  logic [NCELL-1:0]   need2, need3, err_v, mask2, mask3_q, erased_v;
  logic               nxt_empty, done_q, fail_q, err_q;

  mlc_cell_cmp #(.NCELL(NCELL)) u_cmp (
    .tgt_i(tgt_q), .cur_i(cur_q),
    .need2_o(need2), .need3_o(need3), .err_o(err_v)
  );

  mlc_vfy_mask #(.NCELL(NCELL)) u_mask (
    .clk_i, .rst_ni,
    .load_i(st_q == ST_CMP), .load_val_i(need2),
    .vfy_i(st_q == ST_P2_VFY), .tgt_i(tgt_q),
    .vfy_lo_i, .vfy_hi_i,
    .mask_o(mask2), .nxt_empty_o(nxt_empty)
  );

  assign hold_eff = (hold_q == '0) ? HOLD_W'(1) : hold_q;
  assign reload   = hold_eff - HOLD_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; tgt_q <= '0; cur_q <= '0; hold_q <= '0;
      cnt_q <= '0; step_q <= '0; mask3_q <= '0;
      done_q <= 1'b0; fail_q <= 1'b0; err_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          tgt_q <= wbuf_i; cur_q <= rdat_i; hold_q <= hold_i;
          step_q <= '0; done_q <= 1'b0; fail_q <= 1'b0; err_q <= 1'b0;
          st_q <= ST_CMP;
        end
        ST_CMP: begin
          err_q   <= |err_v;
          mask3_q <= need3;
          cnt_q   <= reload;
          if (|need2)      st_q <= ST_P2_PULSE;
          else if (|need3) st_q <= ST_P3_PULSE;
          else begin done_q <= 1'b1; st_q <= ST_IDLE; end
        end
        ST_P2_PULSE: begin
          if (cnt_q == '0) st_q <= ST_P2_VFY;
          else             cnt_q <= cnt_q - HOLD_W'(1);
        end
        ST_P2_VFY: begin
          cnt_q <= reload;
          if (nxt_empty) begin
            if (|mask3_q) st_q <= ST_P3_PULSE;
            else begin done_q <= 1'b1; st_q <= ST_IDLE; end
          end else if (step_q == STEP_MAX) begin
            fail_q <= 1'b1; done_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st_q   <= ST_P2_PULSE;
          end
        end
        ST_P3_PULSE: begin
          if (cnt_q != '0) cnt_q <= cnt_q - HOLD_W'(1);
          else if (step_q == STEP_MAX) begin
            done_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            step_q <= step_q + STEP_W'(1);
            cnt_q  <= reload;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pgm_en_o = '0;
    if (st_q == ST_P2_PULSE)      pgm_en_o = mask2;
    else if (st_q == ST_P3_PULSE) pgm_en_o = mask3_q;
  end

  for (genvar g = 0; g < NCELL; g++) begin : g_er
    assign erased_v[g] = (tgt_q[2*g +: 2] == 2'b11);
  end

  assign step_o    = step_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign cmp_err_o = err_q;

  // R4
  erased_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_en_o & erased_v) == '0);
  // R3
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_en_o & err_v) == '0);
  // R5
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |->
      (step_o == $past(step_o)) || (step_o == $past(step_o) + STEP_W'(1)));
  // R2
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(tgt_q) && $stable(hold_q));
  // R10
  end_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R10
  fail_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);
endmodule

// File: tb/tb_mlc_stair_prog.sv
module tb_mlc_stair_prog;
  localparam int NCELL = 8, STEPS = 107, HOLD_W = 4;
  localparam int STEP_W = $clog2(STEPS);
  localparam int MAXS = STEPS - 1;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [HOLD_W-1:0]  hold = '0;
  logic [2*NCELL-1:0] wbuf = '0, rdat = '0;
  logic [NCELL-1:0]   vfy_lo, vfy_hi, pgm_en;
  logic [STEP_W-1:0]  step;
  logic busy, done, fail, cmp_err;
  int thr_lo [NCELL];
  int thr_hi [NCELL];
  int nvec = 0, nerr = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NCELL; i++) begin
      vfy_lo[i] = int'(step) >= thr_lo[i];
      vfy_hi[i] = int'(step) >= thr_hi[i];
    end

  mlc_stair_prog #(.NCELL(NCELL), .STEPS(STEPS), .HOLD_W(HOLD_W)) dut (
    .clk_i(clk), .rst_ni, .start_i(start), .hold_i(hold),
    .wbuf_i(wbuf), .rdat_i(rdat), .vfy_lo_i(vfy_lo), .vfy_hi_i(vfy_hi),
    .step_o(step), .pgm_en_o(pgm_en), .busy_o(busy), .done_o(done),
    .fail_o(fail), .cmp_err_o(cmp_err)
  );

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(logic [2*NCELL-1:0] w, logic [2*NCELL-1:0] r,
                          logic [HOLD_W-1:0] h, bit poke);
    int he, s2, base, busy_exp, step_exp, cyc;
    bit any2, any3, fl, err;
    int cnt [NCELL];
    int exp_p [NCELL];
    he = (h == 0) ? 1 : int'(h);
    any2 = 0; any3 = 0; err = 0; s2 = 0;
    for (int i = 0; i < NCELL; i++) begin
      int t, c, tr;
      t = 3 - int'(w[2*i +: 2]); c = 3 - int'(r[2*i +: 2]);
      tr = (w[2*i +: 2] == 2'b10) ? thr_lo[i] : thr_hi[i];
      if (t < c) err = 1;
      if (t > c && t < 3) begin any2 = 1; if (tr > s2) s2 = tr; end
      if (t > c && t == 3) any3 = 1;
    end
    fl = any2 && (s2 > MAXS);
    if (s2 > MAXS) s2 = MAXS;
    base = any2 ? s2 : 0;
    busy_exp = 1;
    if (any2) busy_exp += (s2 + 1) * (he + 1);
    if (any3 && !fl) busy_exp += (MAXS - base + 1) * he;
    step_exp = (fl || any3) ? MAXS : (any2 ? s2 : 0);
    for (int i = 0; i < NCELL; i++) begin
      int t, c, tr;
      t = 3 - int'(w[2*i +: 2]); c = 3 - int'(r[2*i +: 2]);
      tr = (w[2*i +: 2] == 2'b10) ? thr_lo[i] : thr_hi[i];
      exp_p[i] = 0;
      if (t > c && t < 3) exp_p[i] = ((tr > MAXS ? MAXS : tr) + 1) * he;
      if (t > c && t == 3 && !fl) exp_p[i] = (MAXS - base + 1) * he;
      cnt[i] = 0;
    end
    @(negedge clk);
    wbuf = w; rdat = r; hold = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      cyc++;
      for (int i = 0; i < NCELL; i++) cnt[i] += int'(pgm_en[i]);
      start = (poke && cyc == 3 && busy_exp > 6);
      // scramble buffer inputs while busy: must be ignored (R2)
      wbuf = $urandom(); rdat = $urandom(); hold = $urandom();
      @(negedge clk);
    end
    start = 1'b0;
    chk(poke ? "R2/R5/R8 busy cycles (start poked)" : "R5/R8/R9 busy cycles",
        cyc, busy_exp);
    repeat (2) @(negedge clk);
    chk("R10 done held", int'(done), 1);
    chk("R7 fail", int'(fail), int'(fl));
    chk("R3 cmp_err", int'(cmp_err), int'(err));
    chk("R5/R8 final step", int'(step), step_exp);
    for (int i = 0; i < NCELL; i++)
      chk($sformatf("R4/R6/R8 pulses cell %0d", i), cnt[i], exp_p[i]);
  endtask

  task automatic rand_thr(int lim);
    for (int i = 0; i < NCELL; i++) begin
      thr_lo[i] = $urandom_range(lim);
      thr_hi[i] = $urandom_range(lim);
    end
  endtask

  function automatic logic [2*NCELL-1:0] biased_rdat();
    logic [2*NCELL-1:0] v;
    for (int i = 0; i < NCELL; i++)
      v[2*i +: 2] = ($urandom_range(9) < 6) ? 2'b11 : 2'($urandom());
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCELL; i++) begin thr_lo[i] = 0; thr_hi[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 cmp_err", int'(cmp_err), 0);
    chk("R1 pgm_en", int'(pgm_en), 0);
    chk("R1 step", int'(step), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 nothing to do
    run_case('1, '1, 4'd2, 0);
    // R3 charge-removing targets only
    run_case('1, '0, 4'd1, 0);
    // R9 top-level-only ramp with hold 0
    run_case('0, '1, 4'd0, 0);
    // R6 lo/hi distinguished: 10 targets, hi verifies early, lo late
    for (int i = 0; i < NCELL; i++) begin thr_lo[i] = 20 + i; thr_hi[i] = 2; end
    run_case({NCELL{2'b10}}, '1, 4'd2, 1);
    // R7 verify exactly at last step passes, then phase 3
    for (int i = 0; i < NCELL; i++) begin thr_lo[i] = 3; thr_hi[i] = 3; end
    thr_hi[1] = MAXS;
    run_case({{(NCELL-2){2'b00}}, 2'b01, 2'b10}, '1, 4'd1, 0);
    // R7 one beyond last step fails
    thr_hi[1] = MAXS + 1;
    run_case({{(NCELL-2){2'b00}}, 2'b01, 2'b10}, '1, 4'd1, 0);

    for (int n = 0; n < 50; n++) begin
      rand_thr(($urandom_range(7) == 0) ? 115 : 40);
      run_case(2*NCELL'($urandom()), biased_rdat(), HOLD_W'($urandom_range(3)),
               ($urandom_range(3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule